// File: doc/BRIEF.md
# DRAM Bank Issue Scheduler

This block decides, once per memory cycle, which queued request on a single DRAM channel is sent to its bank next. The timing model is closed-page with the column command posted straight after the activate, so one issue occupies a bank for a fixed time and the shared data path for a fixed time. Requests enter through one input FIFO. At most one request per cycle is moved from there into a small FIFO belonging to its target bank. A rotating scan then picks the first bank whose head request meets every timing rule.

Three bus countdowns make the data-path bubbles asymmetric. A basic occupancy applies after every issue. A longer hold applies to writes that follow a read. Another hold applies to reads aimed at a different rank from the one last used. Refreshes are spread over time, one bank at a time. A refresh goes out when the scan reaches the bank that is due, and it is treated like a write. An external activate-window limiter supplies a per-rank permission. An external age-batch unit supplies a per-bank veto. The result is an issue strobe with the bank index and the read/write flag, plus a refresh strobe with its bank.

Top module: `dram_bank_sched`

## Requirements
- R1: The global bank index is dimm*RANKS*BANKS + rank*BANKS + bank. Each field is taken from the address at its own configurable start bit, modulo its count. The rank of a bank is the bank index divided by BANKS. With the default parameters the bank index equals address bits [2:0], and the rank equals bits [2:1].
- R2: req_ready is high exactly when the input FIFO is not full. At most one request per cycle moves from the input FIFO head into its bank FIFO. The move happens only if that bank FIFO has room after the current cycle's issue. Otherwise the input head, and everything behind it, waits. A request accepted in cycle c can issue no earlier than cycle c+2.
- R3: At most one activate (issue or refresh) occurs per cycle. After any activate, no further activate occurs until BUS_BASIC cycles later.
- R4: A write head may not issue until BUS_BASIC+RD_WR_DLY cycles after a read issue. After a write or refresh, the wait is BUS_BASIC cycles.
- R5: A read to a rank other than the last-issued rank waits BUS_BASIC+RANK_DLY cycles after a read. A read to the same rank waits only BUS_BASIC cycles. After a write or refresh, any read waits BUS_BASIC cycles.
- R6: A bank that issued or refreshed cannot activate again until BANK_BUSY cycles later.
- R7: The scan starts at the bank after the last issued bank and takes the first ready head. After reset it starts at bank 0.
- R8: A bank whose age_veto bit is high does not issue. No issue or refresh occurs on a rank whose act_ok bit is low.
- R9: Every REF_PERIOD/NB cycles a refresh becomes pending. The first one is pending in cycle REF_PERIOD/NB after reset. Refreshes target banks 0,1,2,… in rotation. A pending refresh is applied when its bank and the bus are idle and its rank is allowed.
- R10: The pending-refresh count saturates at PEND_MAX. A new interval expiry while the count is at the maximum sets ref_overflow, and ref_overflow stays high until reset.
- R11: After reset, no issue or refresh is signalled, ref_overflow is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered this cycle |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | Input FIFO can accept |
| age_veto | input | NB | Per-bank hold from the age-batch unit |
| act_ok | input | NRANK | Per-rank permission from the activate-window limiter |
| iss_valid | output | 1 | A request issues this cycle |
| iss_bank | output | BW | Bank of the issued request |
| iss_write | output | 1 | Issued request is a write |
| ref_valid | output | 1 | A refresh is applied this cycle |
| ref_bank | output | BW | Bank being refreshed |
| ref_overflow | output | 1 | Sticky pending-refresh overflow |

## Verification
The assertions check on every cycle the properties that hold regardless of traffic. Issue and refresh are never signalled together. Activates are spaced by the bus occupancy. No issue occurs on a vetoed bank or a disallowed rank. The overflow flag never drops. The exact cycle counts can only be shown by the bench's scenarios, which compare each issue against a cycle worked out by hand. These cover the read-to-write and rank-switch bubbles, the bank busy time, the round-robin winner on a tie, the address decode, input-FIFO head-of-line blocking, the refresh cadence and rotation, and pending saturation.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
    // Width needed to hold the value maxv (at least one bit).
    function automatic int unsigned cnt_w(int unsigned maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

    function automatic int unsigned idx_w(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/dbs_decode.sv
module dbs_decode #(
    parameter int ADDR_W    = 8,
    parameter int DIMMS     = 2,
    parameter int RANKS     = 2,
    parameter int BANKS     = 2,
    parameter int DIMM_BIT0 = 2,
    parameter int RANK_BIT0 = 1,
    parameter int BANK_BIT0 = 0,
    parameter int BW        = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BW-1:0]     bank
);
    always_comb begin
        int unsigned f_dimm;
        int unsigned f_rank;
        int unsigned f_bank;
        f_dimm = 32'(addr >> DIMM_BIT0) % DIMMS;
        f_rank = 32'(addr >> RANK_BIT0) % RANKS;
        f_bank = 32'(addr >> BANK_BIT0) % BANKS;
        bank   = BW'(f_dimm * RANKS * BANKS + f_rank * BANKS + f_bank);
    end
endmodule

// File: rtl/dbs_fifo.sv
module dbs_fifo #(
    parameter int W     = 4,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    import dbs_pkg::*;
    localparam int AW = idx_w(DEPTH);
    localparam int CW = cnt_w(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t s_q, s_d;
    logic     do_push, do_pop;

    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CW'(DEPTH));
    assign dout  = s_q.mem[s_q.rd];

    always_comb begin
        s_d     = s_q;
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        if (do_push) begin
            s_d.mem[s_q.wr] = din;
            s_d.wr = (s_q.wr == AW'(DEPTH - 1)) ? '0 : s_q.wr + 1'b1;
        end
        if (do_pop) begin
            s_d.rd = (s_q.rd == AW'(DEPTH - 1)) ? '0 : s_q.rd + 1'b1;
        end
        s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/dbs_refresh.sv
module dbs_refresh #(
    parameter int NB       = 8,
    parameter int INTERVAL = 1000,
    parameter int PEND_MAX = 3,
    parameter int BW       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    output logic          pending,
    output logic [BW-1:0] target,
    output logic          overflow
);
    import dbs_pkg::*;
    localparam int TW = cnt_w(INTERVAL);
    localparam int PW = cnt_w(PEND_MAX);

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic [PW-1:0] pend;
        logic [BW-1:0] tgt;
        logic          err;
    } ref_st_t;

    ref_st_t s_q, s_d;
    logic    tick;

    assign pending  = (s_q.pend != '0);
    assign target   = s_q.tgt;
    assign overflow = s_q.err;

    always_comb begin
        s_d   = s_q;
        tick  = (s_q.tmr == '0);
        s_d.tmr = tick ? TW'(INTERVAL - 1) : s_q.tmr - 1'b1;
        if (done) begin
            s_d.tgt = (s_q.tgt == BW'(NB - 1)) ? '0 : s_q.tgt + 1'b1;
        end
        if (tick && !done) begin
            if (s_q.pend == PW'(PEND_MAX)) s_d.err = 1'b1;
            else                           s_d.pend = s_q.pend + 1'b1;
        end else if (!tick && done) begin
            s_d.pend = s_q.pend - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.tmr <= TW'(INTERVAL - 1);
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/dram_bank_sched.sv
module dram_bank_sched #(
    parameter int ADDR_W     = 8,
    parameter int DIMMS      = 2,
    parameter int RANKS      = 2,
    parameter int BANKS      = 2,
    parameter int DIMM_BIT0  = 2,
    parameter int RANK_BIT0  = 1,
    parameter int BANK_BIT0  = 0,
    parameter int IN_DEPTH   = 4,
    parameter int BQ_DEPTH   = 2,
    parameter int BANK_BUSY  = 6,
    parameter int BUS_BASIC  = 2,
    parameter int RD_WR_DLY  = 3,
    parameter int RANK_DLY   = 1,
    parameter int REF_PERIOD = 8000,
    parameter int PEND_MAX   = 3,
    localparam int NB        = DIMMS * RANKS * BANKS,
    localparam int NRANK     = DIMMS * RANKS,
    localparam int BW        = dbs_pkg::idx_w(NB),
    localparam int RW        = dbs_pkg::idx_w(NRANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              req_ready,
    input  logic [NB-1:0]     age_veto,
    input  logic [NRANK-1:0]  act_ok,
    output logic              iss_valid,
    output logic [BW-1:0]     iss_bank,
    output logic              iss_write,
    output logic              ref_valid,
    output logic [BW-1:0]     ref_bank,
    output logic              ref_overflow
);
    import dbs_pkg::*;
    localparam int TURN    = (RD_WR_DLY > RANK_DLY) ? RD_WR_DLY : RANK_DLY;
    localparam int MAXT    = (BANK_BUSY > BUS_BASIC + TURN) ? BANK_BUSY : BUS_BASIC + TURN;
    localparam int CW      = cnt_w(MAXT);
    localparam int REF_INT = (REF_PERIOD / NB < 1) ? 1 : REF_PERIOD / NB;

    typedef struct packed {
        logic [NB-1:0][CW-1:0] busy;
        logic [CW-1:0]         basic;
        logic [CW-1:0]         wr;
        logic [CW-1:0]         rk;
        logic [RW-1:0]         last_rank;
        logic [BW-1:0]         rr;
    } sch_st_t;

    function automatic logic [CW-1:0] dec(logic [CW-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    function automatic logic [RW-1:0] rank_of(logic [BW-1:0] b);
        return RW'(32'(b) / BANKS);
    endfunction

    sch_st_t       s_q, s_d;
    logic [BW-1:0] new_bank;
    logic [BW:0]   in_dout;
    logic          in_empty, in_full, move;
    logic [BW-1:0] in_bank;
    logic [NB-1:0] bq_empty, bq_full, bq_wr, bq_pop;
    logic          ref_pend, ref_due_ovf;
    logic [BW-1:0] ref_tgt;

    dbs_decode #(
        .ADDR_W(ADDR_W), .DIMMS(DIMMS), .RANKS(RANKS), .BANKS(BANKS),
        .DIMM_BIT0(DIMM_BIT0), .RANK_BIT0(RANK_BIT0), .BANK_BIT0(BANK_BIT0), .BW(BW)
    ) u_dec (.addr(req_addr), .bank(new_bank));

    assign req_ready = !in_full;
    assign in_bank   = in_dout[BW:1];
    // a slot freed by this cycle's issue may be reused by the move
    assign move      = !in_empty && (!bq_full[in_bank] || bq_pop[in_bank]);

    dbs_fifo #(.W(BW + 1), .DEPTH(IN_DEPTH)) u_in (
        .clk(clk), .rst_n(rst_n),
        .push(req_valid), .din({new_bank, req_write}),
        .pop(move), .dout(in_dout), .empty(in_empty), .full(in_full)
    );

    for (genvar g = 0; g < NB; g++) begin : g_bq
        assign bq_pop[g] = iss_valid && (iss_bank == BW'(g));
        dbs_fifo #(.W(1), .DEPTH(BQ_DEPTH)) u_bq (
            .clk(clk), .rst_n(rst_n),
            .push(move && (in_bank == BW'(g))), .din(in_dout[0]),
            .pop(bq_pop[g]), .dout(bq_wr[g]),
            .empty(bq_empty[g]), .full(bq_full[g])
        );
    end

    dbs_refresh #(.NB(NB), .INTERVAL(REF_INT), .PEND_MAX(PEND_MAX), .BW(BW)) u_ref (
        .clk(clk), .rst_n(rst_n), .done(ref_valid),
        .pending(ref_pend), .target(ref_tgt), .overflow(ref_due_ovf)
    );
    assign ref_overflow = ref_due_ovf;

    always_comb begin
        s_d       = s_q;
        iss_valid = 1'b0;
        iss_bank  = '0;
        iss_write = 1'b0;
        ref_valid = 1'b0;
        ref_bank  = '0;
        for (int i = 0; i < NB; i++) s_d.busy[i] = dec(s_q.busy[i]);
        s_d.basic = dec(s_q.basic);
        s_d.wr    = dec(s_q.wr);
        s_d.rk    = dec(s_q.rk);
        for (int i = 0; i < NB; i++) begin
            logic [BW-1:0] b;
            logic [RW-1:0] rb;
            b  = BW'((32'(s_q.rr) + 32'(i) + 1) % NB);
            rb = rank_of(b);
            // refresh acts as if it sat at the head of its bank
            if (ref_pend && (ref_tgt == b) && (s_d.busy[b] == '0) &&
                (s_d.basic == '0) && act_ok[rb]) begin
                ref_valid   = 1'b1;
                ref_bank    = b;
                s_d.busy[b] = CW'(BANK_BUSY);
                s_d.basic   = CW'(BUS_BASIC);
                s_d.wr      = CW'(BUS_BASIC);
                s_d.rk      = CW'(BUS_BASIC);
            end
            if (!bq_empty[b] && (s_d.busy[b] == '0) && (s_d.basic == '0) &&
                !age_veto[b] && act_ok[rb] &&
                (bq_wr[b] ? (s_d.wr == '0)
                          : ((rb == s_d.last_rank) || (s_d.rk == '0)))) begin
                iss_valid     = 1'b1;
                iss_bank      = b;
                iss_write     = bq_wr[b];
                s_d.busy[b]   = CW'(BANK_BUSY);
                s_d.basic     = CW'(BUS_BASIC);
                s_d.wr        = bq_wr[b] ? CW'(BUS_BASIC) : CW'(BUS_BASIC + RD_WR_DLY);
                s_d.rk        = bq_wr[b] ? CW'(BUS_BASIC) : CW'(BUS_BASIC + RANK_DLY);
                s_d.last_rank = rb;
                s_d.rr        = b;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.rr <= BW'(NB - 1);
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/dbs_sched_chk.sv
module dbs_sched_chk #(
    parameter int NB        = 8,
    parameter int NRANK     = 4,
    parameter int BANKS     = 2,
    parameter int BUS_BASIC = 2,
    parameter int BW        = 3,
    parameter int RW        = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NB-1:0]    age_veto,
    input logic [NRANK-1:0] act_ok,
    input logic             iss_valid,
    input logic [BW-1:0]    iss_bank,
    input logic             ref_valid,
    input logic [BW-1:0]    ref_bank,
    input logic             ref_overflow
);
    function automatic logic [RW-1:0] rk(logic [BW-1:0] b);
        return RW'(32'(b) / BANKS);
    endfunction

    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(iss_valid && ref_valid));

    if (BUS_BASIC >= 2) begin : g_gap
        p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid || ref_valid) |=> !(iss_valid || ref_valid));
    end

    p_veto_r8: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !age_veto[iss_bank]);

    p_act_iss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> act_ok[rk(iss_bank)]);

    p_act_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |-> act_ok[rk(ref_bank)]);

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_overflow |=> ref_overflow);
endmodule

bind dram_bank_sched dbs_sched_chk #(
    .NB(NB), .NRANK(NRANK), .BANKS(BANKS), .BUS_BASIC(BUS_BASIC), .BW(BW), .RW(RW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .age_veto(age_veto), .act_ok(act_ok),
    .iss_valid(iss_valid), .iss_bank(iss_bank), .ref_valid(ref_valid),
    .ref_bank(ref_bank), .ref_overflow(ref_overflow)
);

// File: tb/tb_dram_bank_sched.sv
`timescale 1ns/1ps
module tb_dram_bank_sched;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, req_valid, req_write, req_ready;
    logic [7:0] req_addr;
    logic [7:0] age_veto;
    logic [3:0] act_ok;
    logic       iss_valid, iss_write, ref_valid, ref_overflow;
    logic [2:0] iss_bank, ref_bank;

    logic       rst2_n, req_ready2, iss_valid2, iss_write2, ref_valid2, ref_overflow2;
    logic [3:0] act2;
    logic [2:0] iss_bank2, ref_bank2;

    dram_bank_sched dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_ready(req_ready), .age_veto(age_veto), .act_ok(act_ok),
        .iss_valid(iss_valid), .iss_bank(iss_bank), .iss_write(iss_write),
        .ref_valid(ref_valid), .ref_bank(ref_bank), .ref_overflow(ref_overflow)
    );

    dram_bank_sched #(.REF_PERIOD(32)) dut2 (
        .clk(clk), .rst_n(rst2_n), .req_valid(1'b0), .req_addr(8'h00),
        .req_write(1'b0), .req_ready(req_ready2), .age_veto(8'h00), .act_ok(act2),
        .iss_valid(iss_valid2), .iss_bank(iss_bank2), .iss_write(iss_write2),
        .ref_valid(ref_valid2), .ref_bank(ref_bank2), .ref_overflow(ref_overflow2)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int got;
    logic found;

    task automatic chk(input string req, input logic ok, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [23:0]     tag;
        logic [1:0]      n;
        logic [2:0][7:0] addr;
        logic [2:0]      wr;
        logic [2:0][2:0] eb;
        logic [2:0][7:0] ec;
    } sc_t;

    function automatic sc_t mk(logic [23:0] tag, logic [1:0] n,
                               logic [7:0] a0, logic w0, logic [2:0] b0, logic [7:0] e0,
                               logic [7:0] a1, logic w1, logic [2:0] b1, logic [7:0] e1,
                               logic [7:0] a2, logic w2, logic [2:0] b2, logic [7:0] e2);
        sc_t s;
        s.tag = tag; s.n = n;
        s.addr[0] = a0; s.wr[0] = w0; s.eb[0] = b0; s.ec[0] = e0;
        s.addr[1] = a1; s.wr[1] = w1; s.eb[1] = b1; s.ec[1] = e1;
        s.addr[2] = a2; s.wr[2] = w2; s.eb[2] = b2; s.ec[2] = e2;
        return s;
    endfunction

    // request k is offered in cycle k; ec = expected issue cycle
    localparam int NSC = 7;
    localparam sc_t TBL [NSC] = '{
        mk("R3", 2, 8'h00,0,0,2,  8'h01,0,1,4,   8'h00,0,0,99), // same-rank reads: basic gap
        mk("R5", 2, 8'h00,0,0,2,  8'h02,0,2,5,   8'h00,0,0,99), // rank switch bubble
        mk("R4", 2, 8'h00,0,0,2,  8'h01,1,1,7,   8'h00,0,0,99), // read then write
        mk("R5", 2, 8'h00,1,0,2,  8'h02,0,2,4,   8'h00,0,0,99), // write then other-rank read
        mk("R6", 2, 8'h00,0,0,2,  8'h00,0,0,8,   8'h00,0,0,99), // same bank busy
        mk("R7", 3, 8'h05,1,5,2,  8'h00,0,0,7,   8'h06,0,6,4),  // rr tie: bank 6 beats 0
        mk("R1", 3, 8'hA7,0,7,2,  8'h5A,0,2,5,   8'hF3,1,3,10)  // decode of high bits
    };

    task automatic do_reset();
        rst_n = 1'b0; rst2_n = 1'b0;
        req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
        age_veto = '0; act_ok = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; rst2_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        act2 = '1;
        // R11 reset state
        do_reset();
        #1;
        chk("R11", !iss_valid, iss_valid, 0);
        chk("R11", !ref_valid, ref_valid, 0);
        chk("R11", !ref_overflow, ref_overflow, 0);
        chk("R11", req_ready, req_ready, 1);
        @(negedge clk);

        // table of scenarios
        for (int s = 0; s < NSC; s++) begin
            do_reset();
            got = 0;
            for (int c = 0; c < 20; c++) begin
                if (c < int'(TBL[s].n)) begin
                    req_valid = 1'b1;
                    req_addr  = TBL[s].addr[c[1:0]];
                    req_write = TBL[s].wr[c[1:0]];
                end else begin
                    req_valid = 1'b0;
                end
                #1;
                if (iss_valid) begin
                    got++;
                    found = 1'b0;
                    for (int j = 0; j < int'(TBL[s].n); j++) begin
                        if (int'(TBL[s].ec[j]) == c) begin
                            found = 1'b1;
                            chk(string'(TBL[s].tag), iss_bank == TBL[s].eb[j], iss_bank, TBL[s].eb[j]);
                            chk(string'(TBL[s].tag), iss_write == TBL[s].wr[j], iss_write, TBL[s].wr[j]);
                        end
                    end
                    chk(string'(TBL[s].tag), found, c, -1);
                end
                @(negedge clk);
            end
            chk(string'(TBL[s].tag), got == int'(TBL[s].n), got, TBL[s].n);
        end

        // R2 / R8: vetoed bank 0 fills, input head stalls, bank 1 held behind it
        do_reset();
        got = 0;
        for (int c = 0; c < 20; c++) begin
            age_veto[0] = (c < 12);
            req_valid = (c < 6);
            req_addr  = (c == 3) ? 8'h01 : 8'h00;
            req_write = 1'b0;
            #1;
            if (c == 6) chk("R2", !req_ready, req_ready, 0);
            if (c >= 2 && c < 12 && iss_valid) got++;
            if (c == 12) chk("R8", iss_valid && iss_bank == 3'd0, iss_bank, 0);
            if (c == 13) chk("R2", !iss_valid, iss_valid, 0);
            if (c == 14) chk("R2", iss_valid && iss_bank == 3'd1, iss_bank, 1);
            @(negedge clk);
        end
        chk("R8", got == 0, got, 0);

        // R8: rank 0 not allowed until cycle 10
        do_reset();
        for (int c = 0; c < 14; c++) begin
            act_ok[0] = (c >= 10);
            req_valid = (c < 2);
            req_addr  = (c == 0) ? 8'h00 : 8'h02;
            req_write = 1'b0;
            #1;
            if (c == 2) chk("R8", !iss_valid, iss_valid, 0);
            if (c == 3) chk("R8", iss_valid && iss_bank == 3'd2, iss_bank, 2);
            if (c > 3 && c < 10) chk("R8", !iss_valid, iss_valid, 0);
            if (c == 10) chk("R8", iss_valid && iss_bank == 3'd0, iss_bank, 0);
            @(negedge clk);
        end

        // R9: refresh every 4 cycles, rotating bank (dut2)
        act2 = '1;
        do_reset();
        for (int c = 0; c < 14; c++) begin
            #1;
            chk("R9", ref_valid2 == (c > 0 && c % 4 == 0), ref_valid2, (c > 0 && c % 4 == 0));
            if (ref_valid2) chk("R9", int'(ref_bank2) == c / 4 - 1, ref_bank2, c / 4 - 1);
            @(negedge clk);
        end

        // R10: refreshes blocked, pending saturates, overflow sticks
        act2 = '0;
        do_reset();
        for (int c = 0; c < 26; c++) begin
            act2 = (c >= 17) ? 4'hF : 4'h0;
            #1;
            if (c < 17) chk("R10", !ref_valid2, ref_valid2, 0);
            if (c == 15) chk("R10", !ref_overflow2, ref_overflow2, 0);
            if (c == 16) chk("R10", ref_overflow2, ref_overflow2, 1);
            if (c == 17) chk("R10", ref_valid2 && ref_bank2 == 3'd0, ref_bank2, 0);
            if (c == 19) chk("R10", ref_valid2 && ref_bank2 == 3'd1, ref_bank2, 1);
            if (c == 25) chk("R10", ref_overflow2, ref_overflow2, 1);
            @(negedge clk);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule